// File: doc/BRIEF.md
# Non-Preemptive Fixed-Priority Bus Arbiter

This block decides which of three masters may drive a shared bus. Each master raises a request line. The arbiter answers with one registered grant line per master. The bus reports a busy flag while a transaction is in flight. Priority is fixed by index, and the lowest index wins.

Arbitration happens only in cycles where busy is low. In those cycles the grant register loads the winning request, or clears to zero when nobody is requesting. While busy is high the grant register keeps its value. A transaction that has started therefore always runs to completion, even if a more important master asks for the bus part-way through.

A granted master is expected to raise busy in the cycle after it sees its grant, and to drop busy when it is done. On the next idle cycle the grant is released, passed to another master, or kept by the same master if that master is still the best requester.

Top module: `prio_bus_arbiter`

## Requirements
- R1: While the active-low asynchronous reset rst_ni is low, every grant output is 0.
- R2: At most one bit of gnt_o is 1 in any cycle.
- R3: When busy_i is 1 at a clock edge, gnt_o after that edge equals gnt_o before it.
- R4: When busy_i is 0 at a clock edge, gnt_o after that edge has exactly the bit of the lowest-index asserted bit of req_i set. Bit k of req_i and of gnt_o belongs to master k.
- R5: When busy_i is 0 and req_i is all zero at a clock edge, gnt_o is all zero after that edge.
- R6: When masters 1 and 2 request together and master 0 does not, master 1 is granted. When all three request, master 0 is granted.
- R7: A request from a higher-priority master that arrives while busy_i is 1 does not take the grant away from the current holder. It is served at the first edge where busy_i is 0.
- R8: A master that is still the highest-priority requester at an idle edge keeps its grant, so it can run back-to-back transactions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 3 | Request lines, bit k from master k |
| busy_i | input | 1 | Bus transaction in progress |
| gnt_o | output | 3 | Registered grant lines, bit k to master k |

## Verification
Every grant result is due exactly one clock edge after the req_i and busy_i values that produced it. No other register lies between the inputs and gnt_o. The bench changes inputs on the falling edge and lets one rising edge pass. It then compares gnt_o on the next falling edge against a model that it advances once for that same edge. The expected grant is never sampled on the edge that produces it. Directed sequences cover simultaneous requests, a preempt attempt during busy, back-to-back ownership and idle cycles. A seeded random phase follows them.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned NUM_MASTERS = 3;
endpackage

// File: rtl/arb_prio_pick.sv
// Combinational fixed-priority picker: lowest index wins.
module arb_prio_pick #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] pick_o
);
  logic [N:0] taken;

  assign taken[0] = 1'b0;

  for (genvar k = 0; k < N; k++) begin : g_chain
    assign pick_o[k]    = req_i[k] & ~taken[k];
    assign taken[k + 1] = taken[k] | req_i[k];
  end
endmodule

// File: rtl/arb_grant_reg.sv
// Grant register: loads on idle cycles, holds while the bus is busy.
module arb_grant_reg #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hold_i,
  input  logic [N-1:0] next_i,
  output logic [N-1:0] gnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_o <= '0;
    end else if (!hold_i) begin
      gnt_o <= next_i;
    end
  end
endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter #(
  parameter int unsigned N_MST = arb_pkg::NUM_MASTERS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_MST-1:0] req_i,
  input  logic             busy_i,
  output logic [N_MST-1:0] gnt_o
);
  logic [N_MST-1:0] pick;

  arb_prio_pick #(.N(N_MST)) u_pick (
    .req_i  (req_i),
    .pick_o (pick)
  );

  arb_grant_reg #(.N(N_MST)) u_gnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (busy_i),
    .next_i (pick),
    .gnt_o  (gnt_o)
  );
endmodule

// File: rtl/prio_bus_arbiter_chk.sv
module prio_bus_arbiter_chk #(
  parameter int unsigned N_MST = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_MST-1:0] req_i,
  input logic             busy_i,
  input logic [N_MST-1:0] gnt_o
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_clear_chk: assert (gnt_o == '0);
    end
  end

  // R2
  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  // R3
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(gnt_o));

  // R5
  idle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && req_i == '0) |=> gnt_o == '0);

  // R6
  top_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && req_i[0]) |=> gnt_o[0]);

  for (genvar k = 0; k < N_MST; k++) begin : g_mst
    // R4
    no_req_no_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_i && !req_i[k]) |=> !gnt_o[k]);
  end
endmodule

bind prio_bus_arbiter prio_bus_arbiter_chk #(.N_MST(N_MST)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .busy_i (busy_i),
  .gnt_o  (gnt_o)
);

// File: tb/prio_bus_arbiter_tb.sv
module prio_bus_arbiter_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] req = '0;
  logic       busy = 1'b0;
  logic [2:0] gnt;
  logic [2:0] exp_gnt = '0;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  prio_bus_arbiter u_dut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .req_i  (req),
    .busy_i (busy),
    .gnt_o  (gnt)
  );

  always #4 clk = ~clk;

  function automatic logic [2:0] pick_ref(input logic [2:0] r);
    if (r[0]) return 3'b001;
    if (r[1]) return 3'b010;
    if (r[2]) return 3'b100;
    return 3'b000;
  endfunction

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: gnt=%b expected=%b", tag, act, exp);
    end
  endtask

  // Drive at negedge, one rising edge, compare at next negedge.
  task automatic step(input logic [2:0] r, input logic b, input string tag);
    req  = r;
    busy = b;
    @(posedge clk);
    exp_gnt = b ? exp_gnt : pick_ref(r);
    @(negedge clk);
    check(tag, gnt, exp_gnt);
    if (!$onehot0(gnt)) check("R2", gnt, 3'b000);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: gnt=%b expected=%b", gnt, exp_gnt);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    req = 3'b111;
    repeat (3) @(negedge clk);
    check("R1", gnt, 3'b000);
    rst_ni = 1'b1;
    req = '0;

    // R5 idle with no requests
    step(3'b000, 1'b0, "R5");
    step(3'b000, 1'b0, "R5");
    // R6 simultaneous requests
    step(3'b111, 1'b0, "R6");
    step(3'b110, 1'b0, "R6");
    step(3'b100, 1'b0, "R4");
    step(3'b101, 1'b0, "R6");
    // R7 master 2 holds, master 0 arrives mid-transaction
    step(3'b100, 1'b0, "R4");
    step(3'b100, 1'b1, "R3");
    step(3'b101, 1'b1, "R7");
    step(3'b111, 1'b1, "R7");
    check("R7", gnt, 3'b100);
    step(3'b001, 1'b0, "R7");
    check("R7", gnt, 3'b001);
    // R8 back-to-back by master 0
    step(3'b001, 1'b1, "R3");
    step(3'b001, 1'b0, "R8");
    step(3'b011, 1'b1, "R8");
    step(3'b011, 1'b0, "R8");
    check("R8", gnt, 3'b001);
    // release then idle
    step(3'b000, 1'b0, "R5");
    check("R5", gnt, 3'b000);
    // busy with no grant keeps zero
    step(3'b010, 1'b1, "R3");
    check("R3", gnt, 3'b000);

    for (int i = 0; i < 600; i++) begin
      logic [2:0] r;
      logic       b;
      r = 3'($urandom_range(0, 7));
      b = ($urandom_range(0, 99) < 55);
      step(r, b, b ? "R3" : "R4");
    end

    // R1 asynchronous reset mid-run
    step(3'b010, 1'b0, "R4");
    #2 rst_ni = 1'b0;
    #1 check("R1", gnt, 3'b000);
    exp_gnt = '0;
    @(negedge clk);
    rst_ni = 1'b1;
    step(3'b000, 1'b0, "R5");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule